// File: doc/BRIEF.md
# Indexed-Port Packet Buffer Host Interface

This block is the device side of a small network-controller host interface. The host sees only two locations. The index port latches the number of an internal register. The data port then reads or writes the register that the index selects. Behind the data port sit a few control and status registers and a word-wide packet memory. That memory is split into a transmit region at the bottom and a receive region above it.

Two byte pointers address the memory. The write pointer serves the auto-increment write command. The read pointer serves the auto-increment read command and also a peek command that leaves the pointer where it is. Every auto-increment access moves its pointer by two bytes. When the partition bit is set, each pointer wraps inside its own region. When it is clear, both pointers wrap over the whole memory. The soft-reset bit and the transmit-request bit each read back as busy for a fixed number of cycles and then clear themselves. A finished transmit request raises a status bit that the host clears by writing 1 to it.

Top module: `idx_sram_port`

## Requirements
- R1: After the asynchronous reset, the index latch reads 0, the control, transmit-request, status and mask registers read 0, the write pointer reads 0 and the read pointer reads the receive-region base TX_BYTES.
- R2: A write to the index port (port_i=0) latches wdata_i[7:0]. A read of the index port returns that byte, zero-extended.
- R3: A data-port write with index 0xF8 stores wdata_i at the write pointer, then advances the pointer by 2. A data-port read with index 0xF2 returns the word at the read pointer, then advances the pointer by 2.
- R4: A data-port read with index 0xF0 returns the word at the read pointer and leaves the pointer unchanged.
- R5: With bit 7 of the mask register (index 0xFF) set, the write pointer wraps from TX_BYTES-2 to 0 and the read pointer wraps from MEM_BYTES-2 to TX_BYTES.
- R6: With bit 7 of the mask register clear, both pointers wrap from MEM_BYTES-2 to 0.
- R7: The transmit length is stored as a low byte at index 0xFC and a high byte at index 0xFD. Each byte is written from wdata_i[7:0] and read back on its own.
- R8: Writing 1 to bit 0 at index 0x02 makes that bit read 1 for TX_CYCLES cycles. The bit then reads 0, and bit 1 of the status register (index 0xFE) is set on the same edge.
- R9: Writing 1 to bit 0 at index 0x00 makes that bit read 1 for RST_CYCLES cycles. When it clears, the index latch, both pointers, the status, mask and length registers all return to their reset values.
- R10: Status register bits clear when 1 is written to them and are unchanged by a written 0. A pulse on rx_done_i sets bit 0. A set on the same edge as a clear wins.
- R11: A data-port write at index 0xF4 loads the read pointer and one at index 0xFA loads the write pointer, with bit 0 forced to 0. Reads at the same indices return the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| port_i | input | 1 | 0 = index port, 1 = data port |
| wdata_i | input | 16 | Host write data |
| rx_done_i | input | 1 | Receive-complete event pulse |
| rdata_o | output | 16 | Host read data for the current access |

## Verification
The pointers are driven across each wrap point with both settings of the partition bit. This separates whole-memory wrapping from per-region wrapping, and in partition mode it shows the read pointer landing on the receive base rather than 0. Peek reads alternate with incrementing reads at the same address to show that only one of them moves the pointer. The two self-clearing bits are polled every cycle, so a busy window one cycle too long or too short shows up. Status clears are tried with ones, with zeros, and on the same edge as a receive event.

// File: rtl/idx_sram_pkg.sv
package idx_sram_pkg;
  typedef logic [7:0] idx_t;
  localparam idx_t IX_CTRL  = 8'h00;
  localparam idx_t IX_TXC   = 8'h02;
  localparam idx_t IX_PEEK  = 8'hF0;
  localparam idx_t IX_RDINC = 8'hF2;
  localparam idx_t IX_RPTR  = 8'hF4;
  localparam idx_t IX_WRINC = 8'hF8;
  localparam idx_t IX_WPTR  = 8'hFA;
  localparam idx_t IX_LENL  = 8'hFC;
  localparam idx_t IX_LENH  = 8'hFD;
  localparam idx_t IX_ISR   = 8'hFE;
  localparam idx_t IX_IMR   = 8'hFF;
  localparam int   PART_BIT = 7;
endpackage

// File: rtl/idx_sram_ptr.sv
module idx_sram_ptr #(
  parameter int unsigned PTR_W   = 10,
  parameter int unsigned RST_VAL = 0,
  parameter int unsigned PART_LO = 0,
  parameter int unsigned PART_HI = 192,
  parameter int unsigned FULL_HI = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             part_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, step_val;
  logic [PTR_W:0]   nxt;

  always_comb begin
    nxt = {1'b0, ptr_q} + (PTR_W+1)'(2);
    if (part_i)
      step_val = (nxt >= (PTR_W+1)'(PART_HI)) ? PTR_W'(PART_LO) : nxt[PTR_W-1:0];
    else
      step_val = (nxt >= (PTR_W+1)'(FULL_HI)) ? '0 : nxt[PTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= PTR_W'(RST_VAL);
    else if (clr_i)   ptr_q <= PTR_W'(RST_VAL);
    else if (load_i)  ptr_q <= load_val_i & ~PTR_W'(1);
    else if (step_i)  ptr_q <= step_val;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/idx_sram_busy.sv
module idx_sram_busy #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= CW'(CYCLES);
    else if (busy_o)             cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/idx_sram_mem.sv
module idx_sram_mem #(
  parameter int unsigned WORDS = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [15:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [15:0]   rdata_o
);
  logic [15:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/idx_sram_port.sv
module idx_sram_port
  import idx_sram_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 1024,
  parameter int unsigned TX_BYTES   = MEM_BYTES * 3 / 16,
  parameter int unsigned TX_CYCLES  = 8,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic        port_i,
  input  logic [15:0] wdata_i,
  input  logic        rx_done_i,
  output logic [15:0] rdata_o
);
  localparam int unsigned PTR_W = $clog2(MEM_BYTES);
  localparam int unsigned WORDS = MEM_BYTES / 2;
  localparam int unsigned AW    = PTR_W - 1;

  idx_t        idx_q;
  logic [7:0]  imr_q;
  logic [15:0] len_q;
  logic [1:0]  isr_q, isr_clr;
  logic [PTR_W-1:0] rptr, wptr;
  logic [15:0] mem_rd;
  logic rst_busy, rst_done, tx_busy, tx_done, part;

  wire acc_wr = cs_i & we_i;
  wire dat_wr = acc_wr & port_i;
  wire dat_rd = cs_i & ~we_i & port_i;

  assign part = imr_q[PART_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (rst_done)          idx_q <= '0;
    else if (acc_wr && !port_i) idx_q <= wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q <= '0;
      len_q <= '0;
    end else if (rst_done) begin
      imr_q <= '0;
      len_q <= '0;
    end else if (dat_wr) begin
      if (idx_q == IX_IMR)  imr_q       <= wdata_i[7:0];
      if (idx_q == IX_LENL) len_q[7:0]  <= wdata_i[7:0];
      if (idx_q == IX_LENH) len_q[15:8] <= wdata_i[7:0];
    end
  end

  assign isr_clr = (dat_wr && idx_q == IX_ISR) ? wdata_i[1:0] : 2'b00;

  // events override a same-cycle write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       isr_q <= '0;
    else if (rst_done) isr_q <= '0;
    else               isr_q <= (isr_q & ~isr_clr) | {tx_done, rx_done_i};
  end

  idx_sram_busy #(.CYCLES(RST_CYCLES)) u_rst_busy (
    .clk_i, .rst_ni, .clr_i(1'b0),
    .start_i(dat_wr && idx_q == IX_CTRL && wdata_i[0]),
    .busy_o(rst_busy), .done_o(rst_done)
  );

  idx_sram_busy #(.CYCLES(TX_CYCLES)) u_tx_busy (
    .clk_i, .rst_ni, .clr_i(rst_done),
    .start_i(dat_wr && idx_q == IX_TXC && wdata_i[0]),
    .busy_o(tx_busy), .done_o(tx_done)
  );

  idx_sram_ptr #(
    .PTR_W(PTR_W), .RST_VAL(0), .PART_LO(0), .PART_HI(TX_BYTES), .FULL_HI(MEM_BYTES)
  ) u_wptr (
    .clk_i, .rst_ni, .clr_i(rst_done),
    .load_i(dat_wr && idx_q == IX_WPTR), .load_val_i(wdata_i[PTR_W-1:0]),
    .step_i(dat_wr && idx_q == IX_WRINC), .part_i(part), .ptr_o(wptr)
  );

  idx_sram_ptr #(
    .PTR_W(PTR_W), .RST_VAL(TX_BYTES), .PART_LO(TX_BYTES), .PART_HI(MEM_BYTES),
    .FULL_HI(MEM_BYTES)
  ) u_rptr (
    .clk_i, .rst_ni, .clr_i(rst_done),
    .load_i(dat_wr && idx_q == IX_RPTR), .load_val_i(wdata_i[PTR_W-1:0]),
    .step_i(dat_rd && idx_q == IX_RDINC), .part_i(part), .ptr_o(rptr)
  );

  idx_sram_mem #(.WORDS(WORDS), .AW(AW)) u_mem (
    .clk_i,
    .we_i(dat_wr && idx_q == IX_WRINC),
    .waddr_i(wptr[PTR_W-1:1]), .wdata_i(wdata_i),
    .raddr_i(rptr[PTR_W-1:1]), .rdata_o(mem_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (!port_i) rdata_o = {8'h00, idx_q};
    else begin
      unique case (idx_q)
        IX_CTRL:           rdata_o = {15'b0, rst_busy};
        IX_TXC:            rdata_o = {15'b0, tx_busy};
        IX_PEEK, IX_RDINC: rdata_o = mem_rd;
        IX_RPTR:           rdata_o = 16'(rptr);
        IX_WPTR:           rdata_o = 16'(wptr);
        IX_LENL:           rdata_o = {8'h00, len_q[7:0]};
        IX_LENH:           rdata_o = {8'h00, len_q[15:8]};
        IX_ISR:            rdata_o = {14'b0, isr_q};
        IX_IMR:            rdata_o = {8'h00, imr_q};
        default:           rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/idx_sram_port_chk.sv
module idx_sram_port_chk
  import idx_sram_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 1024,
  parameter int unsigned TX_BYTES  = 192,
  parameter int unsigned PTR_W     = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             we_i,
  input logic             port_i,
  input logic [15:0]      wdata_i,
  input logic             rx_done_i,
  input logic [7:0]       idx_q,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic             tx_busy,
  input logic             rst_done,
  input logic [1:0]       isr_q,
  input logic             part
);
  a_r2_idx_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && !port_i && !rst_done) |=> idx_q == $past(wdata_i[7:0]));

  a_r3_wr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && port_i && idx_q == IX_WRINC && !rst_done)
      |=> (wptr == $past(wptr) + PTR_W'(2)) || (wptr == '0));

  a_r4_peek_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && port_i && idx_q == IX_PEEK && !rst_done) |=> $stable(rptr));

  a_r5_rd_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part && cs_i && !we_i && port_i && idx_q == IX_RDINC && !rst_done &&
     rptr == PTR_W'(MEM_BYTES - 2)) |=> rptr == PTR_W'(TX_BYTES));

  a_r8_tx_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_busy) && !$past(rst_done)) |-> isr_q[1]);

  a_r10_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !rst_done) |=> isr_q[0]);
endmodule

bind idx_sram_port idx_sram_port_chk #(
  .MEM_BYTES(MEM_BYTES), .TX_BYTES(TX_BYTES), .PTR_W(PTR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .port_i(port_i),
  .wdata_i(wdata_i), .rx_done_i(rx_done_i), .idx_q(idx_q), .rptr(rptr),
  .wptr(wptr), .tx_busy(tx_busy), .rst_done(rst_done), .isr_q(isr_q), .part(part)
);

// File: tb/idx_sram_port_tb.sv
module idx_sram_port_tb;
  localparam int MEM = 1024;
  localparam int TXB = 192;
  localparam int TXC = 8;
  localparam int RSC = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_i = 1'b0, we_i = 1'b0, port_i = 1'b0, rx_done_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  idx_sram_port #(.MEM_BYTES(MEM), .TX_BYTES(TXB), .TX_CYCLES(TXC), .RST_CYCLES(RSC)) u_dut (
    .clk_i, .rst_ni, .cs_i, .we_i, .port_i, .wdata_i, .rx_done_i, .rdata_o
  );

  // monitor: compares read data mid-cycle against the expected-value queue
  always @(negedge clk_i) begin
    if (rst_ni && cs_i && !we_i) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected read act=%h exp=<none>", "scoreboard", rdata_o);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          bad++;
          $display("FAIL %s: act=%h exp=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic op(input logic c, input logic w, input logic p, input logic [15:0] d,
                    input logic rx);
    @(posedge clk_i); #1;
    cs_i = c; we_i = w; port_i = p; wdata_i = d; rx_done_i = rx;
  endtask

  task automatic wr(input logic p, input logic [15:0] d);
    op(1'b1, 1'b1, p, d, 1'b0);
  endtask

  task automatic rd(input logic p, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    op(1'b1, 1'b0, p, 16'h0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic rreg(input logic [7:0] ix, input logic [15:0] e, input string t);
    wr(1'b0, {8'h00, ix});
    rd(1'b1, e, t);
  endtask

  task automatic wreg(input logic [7:0] ix, input logic [15:0] d);
    wr(1'b0, {8'h00, ix});
    wr(1'b1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(1'b0, 16'h0000, "R1 index");
    rd(1'b1, 16'h0000, "R1 ctrl");
    rreg(8'hF4, TXB, "R1 rd ptr base");
    rreg(8'hFA, 16'h0000, "R1 wr ptr base");
    rreg(8'hFE, 16'h0000, "R1 status");
    rreg(8'hFF, 16'h0000, "R1 mask");
    rreg(8'h02, 16'h0000, "R1 tx req");

    // R2 index latch
    wr(1'b0, 16'h01A5);
    rd(1'b0, 16'h00A5, "R2 index readback");

    // R3, R6: whole-memory wrap with partition clear
    wreg(8'hFA, 16'(MEM - 4));
    wr(1'b0, 16'h00F8);
    wr(1'b1, 16'h1111);
    wr(1'b1, 16'h2222);
    wr(1'b1, 16'h3333);
    rreg(8'hFA, 16'h0002, "R6 wr ptr wrap to 0");
    wreg(8'hF4, 16'(MEM - 4));
    wr(1'b0, 16'h00F2);
    rd(1'b1, 16'h1111, "R3 inc read 0");
    rd(1'b1, 16'h2222, "R3 inc read 1");
    rd(1'b1, 16'h3333, "R6 inc read after wrap");
    rreg(8'hF4, 16'h0002, "R6 rd ptr wrap to 0");

    // R4 peek
    wreg(8'hF4, 16'(MEM - 2));
    wr(1'b0, 16'h00F0);
    rd(1'b1, 16'h2222, "R4 peek 0");
    rd(1'b1, 16'h2222, "R4 peek 1");
    rreg(8'hF4, 16'(MEM - 2), "R4 rd ptr unchanged");

    // R11 pointer load drops bit 0
    wreg(8'hF4, 16'h0107);
    rd(1'b1, 16'h0106, "R11 rd ptr even");
    wreg(8'hFA, 16'h0033);
    rd(1'b1, 16'h0032, "R11 wr ptr even");

    // R5 partition wrap
    wreg(8'hFF, 16'h0080);
    rd(1'b1, 16'h0080, "R5 mask readback");
    wreg(8'hFA, 16'(TXB - 2));
    wr(1'b0, 16'h00F8);
    wr(1'b1, 16'hAAAA);
    wr(1'b1, 16'hBBBB);
    rreg(8'hFA, 16'h0002, "R5 wr ptr wraps in tx region");
    wreg(8'hF4, 16'(MEM - 2));
    wr(1'b0, 16'h00F2);
    rd(1'b1, 16'h2222, "R5 read at top");
    rreg(8'hF4, TXB, "R5 rd ptr wraps to rx base");
    wreg(8'hF4, 16'h0000);
    wr(1'b0, 16'h00F2);
    rd(1'b1, 16'hBBBB, "R5 write landed at 0");
    wreg(8'hF4, 16'(TXB - 2));
    wr(1'b0, 16'h00F0);
    rd(1'b1, 16'hAAAA, "R5 write at tx top");

    // R7 length bytes
    wreg(8'hFC, 16'h12EE);
    wreg(8'hFD, 16'h3405);
    rd(1'b1, 16'h0005, "R7 len high");
    rreg(8'hFC, 16'h00EE, "R7 len low");

    // R8 transmit request
    wreg(8'hFE, 16'h0003);
    wreg(8'h02, 16'h0001);
    for (int i = 0; i < TXC; i++) rd(1'b1, 16'h0001, "R8 tx busy");
    rd(1'b1, 16'h0000, "R8 tx cleared");
    rreg(8'hFE, 16'h0002, "R8 tx done status");

    // R10 status set and clear
    op(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
    rd(1'b1, 16'h0003, "R10 rx sets bit0");
    wr(1'b1, 16'h0002);
    rd(1'b1, 16'h0001, "R10 clear bit1 only");
    wr(1'b1, 16'h0000);
    rd(1'b1, 16'h0001, "R10 zero write no effect");
    op(1'b1, 1'b1, 1'b1, 16'h0001, 1'b1);
    rd(1'b1, 16'h0001, "R10 set wins over clear");
    wr(1'b1, 16'h0001);
    rd(1'b1, 16'h0000, "R10 clear bit0");

    // R9 soft reset
    op(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
    wreg(8'hFA, 16'h0020);
    wreg(8'h00, 16'h0001);
    for (int i = 0; i < RSC; i++) rd(1'b1, 16'h0001, "R9 reset busy");
    rd(1'b1, 16'h0000, "R9 reset cleared");
    rreg(8'hFF, 16'h0000, "R9 mask cleared");
    rreg(8'hFC, 16'h0000, "R9 len low cleared");
    rreg(8'hFD, 16'h0000, "R9 len high cleared");
    rreg(8'hF4, TXB, "R9 rd ptr to base");
    rreg(8'hFA, 16'h0000, "R9 wr ptr to base");
    rreg(8'hFE, 16'h0000, "R9 status cleared");
    wreg(8'h00, 16'h0001);
    wr(1'b0, 16'h0055);
    idle(RSC + 2);
    rd(1'b0, 16'h0000, "R9 index cleared");

    idle(2);
    finished = 1;
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard: act=%0d exp=0 pending", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule